// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer

This block is a PWM timer with several channels that sits on a simple word-wide register bus. Each channel has two buffer registers: a reload value for the period and a compare value for the duty point. The active counter reads neither buffer directly. Software loads both into the active counter and the active compare register in one of two ways: by holding the channel's manual-update bit for at least one cycle, or by letting auto-reload take them each time the counter reaches zero. Software can therefore prepare the next period while the current one is still running.

Each active counter counts down by one on a tick. The tick comes from a shared free-running prescaler, and each channel selects its own division of 2, 4, 8 or 16. The channel's level goes high after the decrement that brings the counter to the compare value. It drops when the counter reaches zero, and a one-cycle pulse is raised at the same moment. All start, update, invert and auto-reload bits live in one shared control word, and each channel owns a four-bit slice of it.

Top module: `dbuf_pwm_timer`

## Requirements
- R1: After reset every pin and every pulse output is low, and every register reads 0: the control word, the divider selects, the buffers and the live counts.
- R2: A running channel counts down by one per tick. The divider select for channel n sits in bits [2n+1:2n] of the word at 0x04, with codes 0,1,2,3 giving ticks every 2,4,8,16 clocks. With auto-reload, rising edges of the pulse output are reload*div clocks apart.
- R3: Before inversion the level is low after a load or reload. It goes high after the decrement that makes the count equal the compare value, and it returns low when the count reaches zero. For compare < reload it is high for compare*div clocks per period.
- R4: The compare is tested only after a decrement. A compare value equal to the reload value never raises the level, and a compare value of 0 never raises it either.
- R5: Control bit 2 of a slice (invert) inverts the pin. It has no effect on counting.
- R6: Within a slice, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. The slices begin at bit 0 for channel 0 and at bit 4n+4 for channel n>=1. Unimplemented control bits read 0.
- R7: While manual update is 1, the buffers are copied into the active registers every cycle and the level is cleared. Manual update takes priority over a coincident tick, so no decrement happens and no pulse is raised.
- R8: With auto-reload clear, a counter that reaches zero raises exactly one pulse and then stays at zero until the next manual update.
- R9: While start is 0 the live count holds its value. Setting start again resumes counting from the held value.
- R10: Writing a buffer does not change the period in progress. The new value takes effect at the next reload.
- R11: Registers are 32-bit words: divider select at 0x04, control at 0x08, and for channel n the reload buffer at 0x0C+12n, the compare buffer at 0x10+12n and a read-only live count at 0x14+12n.
- R12: The zero-reached pulse lasts exactly one clock. It is raised on the clock on which the count steps from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for one bus word |
| regAddr | input | ADDR_W | Byte address of the word |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr (combinational) |
| pwmPin | output | NUM_CH | PWM level per channel after inversion |
| zeroIrq | output | NUM_CH | One-cycle zero-reached pulse per channel |

## Verification
The collision that matters is a prescaler tick landing while the manual-update bit is still high. Both the load and the decrement want to write the active counter in that cycle. The bench provokes it by setting start and manual update together on a channel with a reload value of 1 and a divider of 2, so ticks arrive every other clock while the load is held. It judges the result at the ports: no pulse may appear, and the live count must still read 1 after many ticks. Pulses must begin within a few clocks once the update bit is cleared.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic load;     // copy buffers into active registers
    logic step;     // decrement this cycle
    logic autoRl;   // reload from buffers on reaching zero
    logic invert;   // flip the pin level
  } chStrobeT;

  localparam int SLICE_W   = 4;
  localparam int BIT_START = 0;
  localparam int BIT_MANUAL = 1;
  localparam int BIT_INVERT = 2;
  localparam int BIT_AUTORL = 3;

  // Start bit of a channel's slice in the shared control word
  function automatic int ctlBase(input int ch);
    return (ch == 0) ? 0 : (4 * ch + 4);
  endfunction

endpackage

// File: rtl/pwm_tmr_ctl.sv
module pwm_tmr_ctl
  import pwm_tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [DATA_W-1:0]              regWdata,
  output logic [DATA_W-1:0]              regRdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   liveCnt,
  output logic [NUM_CH-1:0][CNT_W-1:0]   bufCnt,
  output logic [NUM_CH-1:0][CNT_W-1:0]   bufCmp,
  output chStrobeT [NUM_CH-1:0]          strobe
);

  localparam int PSC_W      = 4;
  localparam int SEL_W      = 2;
  localparam int ADDR_SEL   = 'h04;
  localparam int ADDR_CTRL  = 'h08;
  localparam int CH_FIRST   = 'h0C;
  localparam int CH_STRIDE  = 12;
  localparam int OFF_CMP    = 4;
  localparam int OFF_LIVE   = 8;

  function automatic logic [DATA_W-1:0] ctrlMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++)
      m[ctlBase(c) +: SLICE_W] = '1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_MASK = ctrlMask();

  function automatic logic tickFor(input logic [PSC_W-1:0] c,
                                   input logic [SEL_W-1:0] s);
    case (s)
      2'd0:    return c[0];
      2'd1:    return &c[1:0];
      2'd2:    return &c[2:0];
      default: return &c;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] chAddr(input int ch, input int off);
    return ADDR_W'(CH_FIRST + CH_STRIDE * ch + off);
  endfunction

  logic [DATA_W-1:0]            ctrlReg;
  logic [NUM_CH-1:0][SEL_W-1:0] divSel;
  logic [PSC_W-1:0]             pscCnt;

  // Shared free-running prescaler
  always_ff @(posedge clk) begin
    if (!rstN) pscCnt <= '0;
    else       pscCnt <= pscCnt + 1'b1;
  end

  // Register writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      divSel  <= '0;
      bufCnt  <= '0;
      bufCmp  <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_W'(ADDR_CTRL)) ctrlReg <= regWdata & CTRL_MASK;
      if (regAddr == ADDR_W'(ADDR_SEL))  divSel  <= regWdata[NUM_CH*SEL_W-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (regAddr == chAddr(c, 0))       bufCnt[c] <= regWdata[CNT_W-1:0];
        if (regAddr == chAddr(c, OFF_CMP)) bufCmp[c] <= regWdata[CNT_W-1:0];
      end
    end
  end

  // Read mux
  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) regRdata = ctrlReg;
    if (regAddr == ADDR_W'(ADDR_SEL))  regRdata = DATA_W'(divSel);
    for (int c = 0; c < NUM_CH; c++) begin
      if (regAddr == chAddr(c, 0))        regRdata = DATA_W'(bufCnt[c]);
      if (regAddr == chAddr(c, OFF_CMP))  regRdata = DATA_W'(bufCmp[c]);
      if (regAddr == chAddr(c, OFF_LIVE)) regRdata = DATA_W'(liveCnt[c]);
    end
  end

  // Per-channel strobe generation from the control slices
  for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
    localparam int B = ctlBase(g);
    logic [SLICE_W-1:0] slice;
    logic               tick;
    assign slice = ctrlReg[B +: SLICE_W];
    assign tick  = tickFor(pscCnt, divSel[g]);
    assign strobe[g].load   = slice[BIT_MANUAL];
    assign strobe[g].step   = slice[BIT_START] & tick & ~slice[BIT_MANUAL];
    assign strobe[g].autoRl = slice[BIT_AUTORL];
    assign strobe[g].invert = slice[BIT_INVERT];
  end

endmodule

// File: rtl/pwm_tmr_dp.sv
module pwm_tmr_dp
  import pwm_tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  chStrobeT [NUM_CH-1:0]          strobe,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   bufCnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   bufCmp,
  output logic [NUM_CH-1:0][CNT_W-1:0]   liveCnt,
  output logic [NUM_CH-1:0]              pwmPin,
  output logic [NUM_CH-1:0]              zeroIrq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmpAct;
    logic [CNT_W-1:0] nextCnt;
    logic             lvl;
    logic             irq;

    assign nextCnt = cnt - ONE;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt    <= '0;
        cmpAct <= '0;
        lvl    <= 1'b0;
        irq    <= 1'b0;
      end else begin
        irq <= 1'b0;
        if (strobe[g].load) begin
          cnt    <= bufCnt[g];
          cmpAct <= bufCmp[g];
          lvl    <= 1'b0;
        end else if (strobe[g].step && cnt != '0) begin
          if (cnt == ONE) begin
            irq <= 1'b1;
            lvl <= 1'b0;
            if (strobe[g].autoRl) begin
              cnt    <= bufCnt[g];
              cmpAct <= bufCmp[g];
            end else begin
              cnt <= '0;
            end
          end else begin
            cnt <= nextCnt;
            if (nextCnt == cmpAct) lvl <= 1'b1;
          end
        end
      end
    end

    assign liveCnt[g] = cnt;
    assign pwmPin[g]  = lvl ^ strobe[g].invert;
    assign zeroIrq[g] = irq;
  end

endmodule

// File: rtl/dbuf_pwm_timer.sv
module dbuf_pwm_timer
  import pwm_tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [NUM_CH-1:0] pwmPin,
  output logic [NUM_CH-1:0] zeroIrq
);

  logic [NUM_CH-1:0][CNT_W-1:0] liveCnt;
  logic [NUM_CH-1:0][CNT_W-1:0] bufCnt;
  logic [NUM_CH-1:0][CNT_W-1:0] bufCmp;
  chStrobeT [NUM_CH-1:0]        strobe;

  pwm_tmr_ctl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .liveCnt(liveCnt),
    .bufCnt(bufCnt), .bufCmp(bufCmp), .strobe(strobe)
  );

  pwm_tmr_dp #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bufCnt(bufCnt),
    .bufCmp(bufCmp), .liveCnt(liveCnt), .pwmPin(pwmPin), .zeroIrq(zeroIrq)
  );

endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk
  import pwm_tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input chStrobeT [NUM_CH-1:0]        strobe,
  input logic [NUM_CH-1:0][CNT_W-1:0] liveCnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] bufCnt,
  input logic [NUM_CH-1:0]            zeroIrq
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R2: a tick above 1 decrements by exactly one
    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[g].step && !strobe[g].load && liveCnt[g] > CNT_W'(1))
        |=> liveCnt[g] == $past(liveCnt[g]) - CNT_W'(1));

    // R7: manual update loads the buffer and suppresses the pulse
    assert_load_copies_R7: assert property (@(posedge clk) disable iff (!rstN)
      strobe[g].load |=> (liveCnt[g] == $past(bufCnt[g])) && !zeroIrq[g]);

    // R9: without a step or load the count holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe[g].step && !strobe[g].load) |=> liveCnt[g] == $past(liveCnt[g]));

    // R8: one-shot channel parked at zero stays there
    assert_park_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe[g].load && !strobe[g].autoRl && liveCnt[g] == '0)
        |=> liveCnt[g] == '0);

    // R12: pulse comes from a 1-to-0 step and lasts one clock
    assert_irq_origin_R12: assert property (@(posedge clk) disable iff (!rstN)
      zeroIrq[g] |-> $past(liveCnt[g]) == CNT_W'(1));
    assert_irq_single_R12: assert property (@(posedge clk) disable iff (!rstN)
      zeroIrq[g] |=> !zeroIrq[g]);
  end

endmodule

bind dbuf_pwm_timer pwm_tmr_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .liveCnt(liveCnt),
  .bufCnt(bufCnt), .zeroIrq(zeroIrq)
);

// File: tb/sim_dbuf_pwm_timer.sv
module sim_dbuf_pwm_timer;

  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic [NUM_CH-1:0] pwmPin;
  logic [NUM_CH-1:0] zeroIrq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbuf_pwm_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W))
    u0 (.clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
        .regWdata(regWdata), .regRdata(regRdata), .pwmPin(pwmPin), .zeroIrq(zeroIrq));

  // Vector: channel, divider code, reload, compare, invert
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{0, 0, 8, 3, 0},
    '{1, 1, 5, 2, 1},
    '{2, 2, 4, 4, 0},
    '{3, 3, 3, 1, 0},
    '{0, 0, 5, 0, 0},
    '{2, 1, 7, 6, 1},
    '{1, 0, 1, 0, 0}
  };

  function automatic int base(input int ch);
    return (ch == 0) ? 0 : 4 * ch + 4;
  endfunction

  function automatic int cntA(input int ch); return 'h0C + 12 * ch; endfunction
  function automatic int cmpA(input int ch); return 'h10 + 12 * ch; endfunction
  function automatic int liveA(input int ch); return 'h14 + 12 * ch; endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input int d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = ADDR_W'(a); regWdata = DATA_W'(d);
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input int a, output int d);
    regAddr = ADDR_W'(a);
    #1;
    d = int'(regRdata);
  endtask

  task automatic measure(input int ch, output int per, output int hi);
    int guard = 0;
    per = 0; hi = 0;
    while (zeroIrq[ch] !== 1'b1 && guard < 4000) begin @(posedge clk); #2; guard++; end
    do begin
      if (pwmPin[ch]) hi++;
      per++;
      @(posedge clk); #2;
    end while (zeroIrq[ch] !== 1'b1 && per < 4000);
  endtask

  task automatic waitIrq(input int ch, output int t);
    int guard = 0;
    @(posedge clk); #2;
    while (zeroIrq[ch] !== 1'b1 && guard < 4000) begin @(posedge clk); #2; guard++; end
    t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int rd, per, hi, a, b, c, t0, t1, t2, seen;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    #2;
    // R1 reset state
    check("R1 pins", int'(pwmPin), 0);
    check("R1 irq", int'(zeroIrq), 0);
    busRead('h08, rd); check("R1 ctrl", rd, 0);
    busRead('h04, rd); check("R1 divsel", rd, 0);
    busRead(cntA(2), rd); check("R1 reload buf", rd, 0);
    busRead(liveA(3), rd); check("R1 live", rd, 0);

    // R11 offsets and R6 slice layout
    busWrite(cntA(3), 'h1234);
    busWrite(cmpA(3), 'h0567);
    busRead(cntA(3), rd); check("R11 reload buf ch3", rd, 'h1234);
    busRead(cmpA(3), rd); check("R11 compare buf ch3", rd, 'h0567);
    busWrite('h08, 'hFFFF_FFFF);
    busRead('h08, rd); check("R6 control mask", rd, 'h000F_FF0F);
    busWrite('h08, 0);

    // Table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      int ch, dv, n, m, inv, expP, expH, sl;
      ch = VEC[v][0]; dv = 2 << VEC[v][1]; n = VEC[v][2]; m = VEC[v][3]; inv = VEC[v][4];
      sl = (1 << 3) | (inv << 2);
      busWrite('h08, 0);
      busWrite('h04, VEC[v][1] << (2 * ch));
      busWrite(cntA(ch), n);
      busWrite(cmpA(ch), m);
      busWrite('h08, (sl | 2) << base(ch));
      busWrite('h08, (sl | 1) << base(ch));
      measure(ch, per, hi);
      expP = n * dv;
      expH = (m < n) ? m * dv : 0;
      if (inv != 0) expH = expP - expH;
      check($sformatf("R2 period vec%0d", v), per, expP);
      check($sformatf("R3 R4 R5 high time vec%0d", v), hi, expH);
    end
    busWrite('h08, 0);

    // R7 manual update versus coincident ticks on ch1 (slice at 8)
    busWrite('h04, 0);
    busWrite(cntA(1), 1);
    busWrite(cmpA(1), 0);
    busWrite('h08, 'hB00);
    seen = 0;
    for (int k = 0; k < 20; k++) begin @(posedge clk); #2; if (zeroIrq[1]) seen++; end
    check("R7 no pulse while loading", seen, 0);
    busRead(liveA(1), rd); check("R7 count held at buffer", rd, 1);
    busWrite('h08, 'h900);
    seen = 0;
    for (int k = 0; k < 6; k++) begin @(posedge clk); #2; if (zeroIrq[1]) seen++; end
    check("R7 pulses resume", int'(seen > 0), 1);
    busWrite('h08, 0);

    // R8 one-shot on ch2 (slice at 12)
    busWrite('h04, 1 << 4);
    busWrite(cntA(2), 3);
    busWrite(cmpA(2), 1);
    busWrite('h08, 'h2000);
    busWrite('h08, 'h1000);
    seen = 0;
    for (int k = 0; k < 200; k++) begin @(posedge clk); #2; if (zeroIrq[2]) seen++; end
    check("R8 single pulse", seen, 1);
    busRead(liveA(2), rd); check("R8 parked at zero", rd, 0);
    check("R8 pin low", int'(pwmPin[2]), 0);
    busWrite('h08, 0);

    // R9 stop and resume on ch3 (slice at 16)
    busWrite('h04, 3 << 6);
    busWrite(cntA(3), 50);
    busWrite('h08, 'hB0000);
    busWrite('h08, 'h90000);
    repeat (100) @(posedge clk);
    busWrite('h08, 'h80000);
    #1; busRead(liveA(3), a);
    repeat (100) @(posedge clk);
    #1; busRead(liveA(3), b);
    check("R9 held while stopped", b, a);
    check("R9 count moved before stop", int'(a > 0 && a < 50), 1);
    busWrite('h08, 'h90000);
    repeat (64) @(posedge clk);
    #1; busRead(liveA(3), c);
    check("R9 resumed counting", int'(c < a), 1);
    busWrite('h08, 0);

    // R10 buffer write affects only the next period (ch0, div 2)
    busWrite('h04, 0);
    busWrite(cntA(0), 6);
    busWrite(cmpA(0), 2);
    busWrite('h08, 'hA);
    busWrite('h08, 'h9);
    waitIrq(0, t0);
    busWrite(cntA(0), 10);
    waitIrq(0, t1);
    waitIrq(0, t2);
    check("R10 current period unchanged", t1 - t0, 12);
    check("R10 next period uses new buffer", t2 - t1, 20);
    busWrite('h08, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule